// File: doc/BRIEF.md
# Sixteen-Point Systolic Cosine Transform

This block computes a 16-point discrete cosine transform (the plain, unnormalized type II sum) over a stream of signed samples. Samples arrive one per cycle when `in_valid` is high. Each run of 16 accepted samples forms one block. When a block is complete, the 16 transform outputs leave in order of increasing frequency index, one per cycle, with a fixed latency.

The arithmetic is a linear chain of 16 identical processing elements. Each element holds one sample of the current block and has one multiplier and one adder. A partial sum for output k enters the head of the chain. At each element it gains the product of that element's sample and the cosine coefficient for (k, n), then moves to the next element. Sums for successive k follow one another through the chain one cycle apart, each tagged with a valid flag and its index. The last element's sum is rounded to the output width.

Samples reach their elements through a shift chain between neighbours. A completed block is copied into a per-element shadow stage. This lets the next block load while the previous one is still being consumed.

Top module: `systolic_dct16`

## Requirements
- R1: While `rst` is high, `out_valid` is low in the following cycle. Samples offered during reset are discarded, and block grouping starts with the first sample accepted after reset.
- R2: For block samples x[0..15] (the n-th accepted sample of the block, 12-bit two's complement), the accumulated value for index k is the sum of x[n]·C[k][n]. Here C[k][n] = round(cos(π·(2n+1)·k/32)·16384), a signed Q1.14 value with ties rounded away from zero.
- R3: The presented value is (acc + 8192) shifted right arithmetically by 14 bits (round half up), saturated to the signed 16-bit range.
- R4: The 16 results of a block appear on 16 consecutive cycles in increasing k, and `out_index` equals k.
- R5: Result k is registered at the (17+k)-th rising edge after the edge that accepts the block's 16th sample.
- R6: The first sample of a new block may be accepted on the edge right after the previous block's last sample. The outputs of the two blocks then follow each other with no gap, and every value is still correct.
- R7: On a cycle with `in_valid` low, no sample is accepted and `in_sample` has no effect. Idle cycles inside a block do not change its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered this cycle |
| in_sample | input | 12 | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_index | output | 4 | Frequency index k of the result |
| out_coef | output | 16 | Rounded signed transform value |

## Verification
The bench goes after several corner cases, each with a distinct failure signature.

- Back-to-back blocks. A shadow stage released one cycle too early would give the tail of the chain samples from the next block, corrupting the high elements' contribution to the first block's last outputs.
- Idle cycles with random data inside a block. A loader that shifts without checking `in_valid` would permute the samples, so nearly every output would be wrong.
- Full-scale negative and positive constant blocks. A narrow accumulator or rounding that truncates instead of rounding half up would show at the range ends.
- An impulse block. A mis-mapped coefficient index would show as a wrong cosine.
- Sample-to-output timing. This is checked at each result, so a missing or extra pipeline register is caught.

// File: rtl/sdct_pkg.sv
package sdct_pkg;

  localparam int DCT_N     = 16;
  localparam int COEF_FRAC = 14;

  // cos(i*pi/32) in Q1.14 for i = 0..16 (one quarter wave)
  function automatic int quarter_q14(input int i);
    case (i)
      0:  return 16384;
      1:  return 16305;
      2:  return 16069;
      3:  return 15679;
      4:  return 15137;
      5:  return 14449;
      6:  return 13623;
      7:  return 12665;
      8:  return 11585;
      9:  return 10394;
      10: return 9102;
      11: return 7723;
      12: return 6270;
      13: return 4756;
      14: return 3196;
      15: return 1606;
      default: return 0;
    endcase
  endfunction

  // coefficient for frequency k and sample n: cos(pi*(2n+1)*k/32)
  function automatic int cos_q14(input int k, input int n);
    int m;
    m = ((2 * n + 1) * k) % 64;
    if (m <= 16)      return  quarter_q14(m);
    else if (m <= 32) return -quarter_q14(32 - m);
    else if (m <= 48) return -quarter_q14(m - 32);
    else              return  quarter_q14(64 - m);
  endfunction

endpackage

// File: rtl/sdct_loader.sv
module sdct_loader #(
  parameter int N  = 16,
  parameter int SW = 12,
  parameter int KW = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [SW-1:0]         in_sample,
  output logic                  blk_start,
  output logic [N-1:0][SW-1:0]  shadow
);

  logic [KW-1:0]        cnt;
  logic [N-1:0][SW-1:0] chain;
  logic                 last_smp;

  assign last_smp  = in_valid && (cnt == KW'(N - 1));
  assign blk_start = last_smp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (in_valid) begin
      cnt <= last_smp ? '0 : cnt + 1'b1;
    end
  end

  // neighbour-to-neighbour shift chain plus block snapshot
  always_ff @(posedge clk) begin
    if (in_valid) begin
      chain[0] <= in_sample;
      if (last_smp) shadow[0] <= in_sample;
    end
  end

  for (genvar j = 1; j < N; j++) begin : g_stage
    always_ff @(posedge clk) begin
      if (in_valid) begin
        chain[j] <= chain[j-1];
        if (last_smp) shadow[j] <= chain[j-1];
      end
    end
  end

  logic unused_tail;
  assign unused_tail = ^chain[N-1];

endmodule

// File: rtl/sdct_seq.sv
module sdct_seq #(
  parameter int N  = 16,
  parameter int KW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          inj_vld,
  output logic          inj_first,
  output logic [KW-1:0] inj_k
);

  logic          run;
  logic [KW-1:0] k;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      k   <= '0;
    end else if (start) begin
      run <= 1'b1;
      k   <= '0;
    end else if (run) begin
      if (k == KW'(N - 1)) run <= 1'b0;
      else                 k   <= k + 1'b1;
    end
  end

  assign inj_vld   = run;
  assign inj_first = run && (k == '0);
  assign inj_k     = k;

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    start |-> (!run || k == KW'(N - 1))); // R6

endmodule

// File: rtl/sdct_pe.sv
module sdct_pe #(
  parameter int N    = 16,
  parameter int SW   = 12,
  parameter int CW   = 16,
  parameter int AW   = 32,
  parameter int KW   = $clog2(N),
  parameter int SIDX = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SW-1:0]        shadow_smp,
  input  logic                 in_vld,
  input  logic                 in_first,
  input  logic [KW-1:0]        in_k,
  input  logic signed [AW-1:0] in_sum,
  output logic                 out_vld,
  output logic                 out_first,
  output logic [KW-1:0]        out_k,
  output logic signed [AW-1:0] out_sum
);

  localparam int PW = SW + CW;

  logic [SW-1:0]        held;
  logic signed [SW-1:0] smp_use;
  logic signed [CW-1:0] coef;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;

  // coefficient ROM slice for this sample position, indexed by k
  assign coef     = CW'(sdct_pkg::cos_q14(int'(in_k), SIDX));
  assign smp_use  = in_first ? shadow_smp : held;
  assign prod     = smp_use * coef;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_first <= 1'b0;
    end else begin
      out_vld   <= in_vld;
      out_first <= in_vld && in_first;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_sum <= in_sum + prod_ext;
      out_k   <= in_k;
      if (in_first) held <= shadow_smp;
    end
  end

  AST_HEAD_K0: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_first) |-> (in_k == '0)); // R4
  AST_K_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !in_first) |-> (out_vld && in_k == KW'(out_k + 1'b1))); // R4

endmodule

// File: rtl/sdct_round.sv
module sdct_round #(
  parameter int AW   = 32,
  parameter int OW   = 16,
  parameter int KW   = 4,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic                 in_first,
  input  logic [KW-1:0]        in_k,
  input  logic signed [AW-1:0] in_sum,
  output logic                 out_vld,
  output logic [KW-1:0]        out_k,
  output logic signed [OW-1:0] out_val
);

  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] VMAX = AW'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [AW-1:0] VMIN = -VMAX - AW'(1);

  logic signed [AW-1:0] biased;
  logic signed [AW-1:0] shifted;
  logic signed [OW-1:0] clipped;

  assign biased  = in_sum + HALF;
  assign shifted = biased >>> FRAC;

  always_comb begin
    if (shifted > VMAX)      clipped = VMAX[OW-1:0];
    else if (shifted < VMIN) clipped = VMIN[OW-1:0];
    else                     clipped = shifted[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_val <= clipped;
      out_k   <= in_k;
    end
  end

  AST_ROUND_HEAD: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_first) |-> (in_k == '0)); // R4

endmodule

// File: rtl/systolic_dct16.sv
module systolic_dct16 #(
  parameter int SW = 12,
  parameter int CW = 16,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [SW-1:0] in_sample,
  output logic          out_valid,
  output logic [3:0]    out_index,
  output logic [OW-1:0] out_coef
);

  localparam int N  = sdct_pkg::DCT_N;
  localparam int KW = $clog2(N);
  localparam int AW = SW + CW + KW;

  logic                 blk_start;
  logic [N-1:0][SW-1:0] shadow;

  logic                 vld   [N+1];
  logic                 first [N+1];
  logic [KW-1:0]        kidx  [N+1];
  logic signed [AW-1:0] psum  [N+1];

  sdct_loader #(.N(N), .SW(SW), .KW(KW)) u_loader (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .blk_start(blk_start),
    .shadow   (shadow)
  );

  sdct_seq #(.N(N), .KW(KW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (blk_start),
    .inj_vld  (vld[0]),
    .inj_first(first[0]),
    .inj_k    (kidx[0])
  );

  assign psum[0] = '0;

  // element j holds sample n = N-1-j (oldest sample sits furthest along)
  for (genvar j = 0; j < N; j++) begin : g_pe
    sdct_pe #(
      .N(N), .SW(SW), .CW(CW), .AW(AW), .KW(KW), .SIDX(N - 1 - j)
    ) u_pe (
      .clk       (clk),
      .rst       (rst),
      .shadow_smp(shadow[j]),
      .in_vld    (vld[j]),
      .in_first  (first[j]),
      .in_k      (kidx[j]),
      .in_sum    (psum[j]),
      .out_vld   (vld[j+1]),
      .out_first (first[j+1]),
      .out_k     (kidx[j+1]),
      .out_sum   (psum[j+1])
    );
  end

  logic signed [OW-1:0] res;
  logic [KW-1:0]        res_k;

  sdct_round #(.AW(AW), .OW(OW), .KW(KW), .FRAC(sdct_pkg::COEF_FRAC)) u_round (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (vld[N]),
    .in_first(first[N]),
    .in_k    (kidx[N]),
    .in_sum  (psum[N]),
    .out_vld (out_valid),
    .out_k   (res_k),
    .out_val (res)
  );

  assign out_index = res_k;
  assign out_coef  = res;

  AST_OUT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && out_index != 4'd0)
      |-> (out_index == 4'($past(out_index) + 1'b1))); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !out_valid); // R1

endmodule

// File: tb/systolic_dct16_test.sv
`timescale 1ns/1ps
module systolic_dct16_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] in_sample = '0;
  logic        out_valid;
  logic [3:0]  out_index;
  logic [15:0] out_coef;

  systolic_dct16 uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_index(out_index), .out_coef(out_coef)
  );

  always #2.5 clk = ~clk;

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  logic [31:0] lfsr = 32'h1ACE_5EED;
  int     blk [16];
  bit     done = 1'b0;

  int     q_k [$];
  int     q_v [$];
  longint q_t [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rnd12();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'($signed(lfsr[11:0]));
  endfunction

  // R2/R3 expected value from the transform definition
  function automatic int model_y(int k);
    longint acc = 0;
    for (int n = 0; n < 16; n++) begin
      real v;
      int  c;
      v = $cos(3.14159265358979323846 * real'((2 * n + 1) * k) / 32.0) * 16384.0;
      c = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
      acc += longint'(blk[n]) * longint'(c);
    end
    acc = (acc + 8192) >>> 14;
    if (acc > 32767)  acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: gap = idle cycles with junk data after each sample (R7)
  task automatic send_block(int gap);
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = blk[n][11:0];
      if (n == 15) begin
        for (int k = 0; k < 16; k++) begin
          q_k.push_back(k);
          q_v.push_back(model_y(k));
          q_t.push_back(cyc + 1 + 17 + k);
        end
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = 12'(rnd12());
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sample = 12'(rnd12());
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_k.size() == 0) begin
        check("R4 unexpected result", 1, 0);
      end else begin
        int     ek, ev;
        longint et;
        ek = q_k.pop_front();
        ev = q_v.pop_front();
        et = q_t.pop_front();
        check("R4 index order", longint'(out_index), longint'(ek));
        check("R2/R3 value", longint'($signed(out_coef)), longint'(ev));
        check("R5 latency", cyc, et);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: junk offered during reset must be dropped
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = 12'(rnd12());
    end
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    check("R1 out_valid after reset", longint'(out_valid), 0);

    // R2 impulse at n=0
    foreach (blk[i]) blk[i] = (i == 0) ? 1000 : 0;
    send_block(0);
    idle(3);

    // R7 ramp with idle cycles carrying junk
    foreach (blk[i]) blk[i] = 100 * i - 700;
    send_block(2);
    idle(5);

    // R3 full-scale negative, then positive
    foreach (blk[i]) blk[i] = -2048;
    send_block(0);
    idle(1);
    foreach (blk[i]) blk[i] = 2047;
    send_block(0);

    // R6 back-to-back random blocks, then alternating extremes
    for (int b = 0; b < 3; b++) begin
      foreach (blk[i]) blk[i] = rnd12();
      send_block(0);
    end
    foreach (blk[i]) blk[i] = (i % 2 == 0) ? 2047 : -2048;
    send_block(0);
    foreach (blk[i]) blk[i] = rnd12();
    send_block(1);

    idle(1);
    while (q_k.size() != 0) @(negedge clk);
    idle(4);
    check("R4 no extra results", longint'(out_valid), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule